// File: doc/BRIEF.md
# Dual Programmable Down-Counter with Interrupt Aggregation

This block is a register-mapped peripheral that holds two independent down-counting timers. Each timer has a reload value, a live count that software can read, and a control register. A control write carries an operation (load the reload value, stop, or run) and a tick-source code. The tick-source code picks one of four single-cycle tick-enable inputs, or no source at all. A running timer moves only on cycles where its selected tick input is high.

When a running timer is at one or zero and a tick arrives, the timer expires. It then reloads from its reload register and sets its own bit in a raw interrupt status register. A mask register gates the raw status into a masked status. A write-one-to-clear acknowledge register clears raw bits. One level interrupt output is high while the masked status is nonzero.

Software reaches every register through a simple 32-bit word bus. A write is a one-cycle strobe with an address and data. Read data is a combinational function of the address.

Top module: `dual_tick_timer`

## Requirements
- R1: After synchronous reset both timers are stopped with count 0, mask and raw status read 0, and `irq` is low. Tick inputs do not move a count until a run command is accepted.
- R2: A control write with operation code 0 in bits [1:0] copies the timer's reload register into its counter. The new count is readable at the timer's count offset after the write cycle.
- R3: A control write with operation code 2 starts the timer. While it runs, the count drops by one on each cycle where the tick input selected by the clock code in bits [4:2] is high. Codes 4, 5, 6 and 7 select `tick_en[0]`, `tick_en[1]`, `tick_en[2]` and `tick_en[3]`. Codes 0 and 1 select no source, so the count never moves. An accepted control write in the same cycle as a tick takes priority, and that tick is dropped.
- R4: A control write with operation code 1 stops the timer. While stopped, the count keeps its value whatever the tick inputs do.
- R5: A tick on a running timer whose count is 1 or 0 reloads the count from the reload register that held before that cycle. It also sets raw status bit 0 for timer 0 or bit 1 for timer 1. A reload value of N therefore gives one expiry every N ticks.
- R6: A write to the acknowledge register clears each raw status bit written as 1 and leaves bits written as 0 unchanged. The written value is not stored. An expiry in the same cycle as an acknowledge of its bit leaves that bit set.
- R7: The masked status reads raw AND mask (2 bits). `irq` is high exactly when the masked status is nonzero, and it follows a mask write from the next cycle.
- R8: A control write is ignored as a whole, with clock code, run state and count unchanged, in three cases: its operation code is 3, its clock code is 2 or 3, or any of bits [31:5] is set.
- R9: Reads of unmapped offsets and of the control and acknowledge offsets return 0. Writes to the status offsets or to unmapped offsets change nothing.
- R10: Word offsets: timer 0 reload 0x00, count 0x04, control 0x08; timer 1 reload 0x10, count 0x14, control 0x18; mask 0x48, acknowledge 0x4C, raw status 0x50, masked status 0x54.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W (8) | Byte offset of the word accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tick_en | input | NUM_TICK (4) | Tick-enable inputs, selected by clock codes 4 to 7 |
| irq | output | 1 | Level interrupt, high while masked status is nonzero |

## Verification
Directed sequences drive the counter with the selected tick alone and with only non-selected ticks high. This shows that the clock-code decode picks the right input and ignores the others. Reload values of 5 and 3 are counted through to expiry, which separates an off-by-one reload from a correct period. An acknowledge in the same cycle as an expiry shows which of the two wins. A long random phase mixes writes to every offset, including reserved operation codes, invalid clock codes and high control bits, with random tick patterns. A bench model of both timers and the status registers is compared against every readable register and `irq` at regular intervals.

// File: rtl/dtt_pkg.sv
// Package for the dual tick timer: register offsets, operation codes and
// the helper that decides whether a control word is accepted.
// Assumes word-aligned offsets; the low two address bits select no byte.
package dtt_pkg;

    localparam int TMR_DIV_OFS   = 8'h00;
    localparam int TMR_CNT_OFS   = 8'h04;
    localparam int TMR_CTRL_OFS  = 8'h08;
    localparam int TMR_STRIDE    = 8'h10;
    localparam int MASK_OFS      = 8'h48;
    localparam int ACK_OFS       = 8'h4C;
    localparam int RAW_OFS       = 8'h50;
    localparam int MASKED_OFS    = 8'h54;

    typedef enum logic [1:0] {
        OP_LOAD = 2'd0,
        OP_STOP = 2'd1,
        OP_RUN  = 2'd2,
        OP_RSVD = 2'd3
    } tmr_op_e;

    // A control word is taken only with a defined op, a defined clock code
    // and clear upper bits.
    function automatic logic ctrl_accept(input logic [31:0] w);
        return (w[1:0] != OP_RSVD) && (w[4:3] != 2'b01) && (w[31:5] == '0);
    endfunction

endpackage

// File: rtl/dtt_timer_chan.sv
// One down-counting timer channel: reload register, counter, run flag and
// tick-source select. Emits a one-cycle hit when it expires and reloads.
// Assumes at most one control write per cycle; an accepted control write
// takes priority over a tick in the same cycle.
module dtt_timer_chan
    import dtt_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int NUM_TICK = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                div_we,
    input  logic                ctrl_we,
    input  logic [31:0]         wdata,
    input  logic [NUM_TICK-1:0] tick_en,
    output logic [CNT_W-1:0]    div_q,
    output logic [CNT_W-1:0]    cnt_q,
    output logic                run_q,
    output logic                hit
);

    localparam int SEL_W = 3;

    logic [SEL_W-1:0] sel_q;
    logic             take_ctrl;
    logic             src_tick;
    logic             adv;
    tmr_op_e          op;

    // Decode the control command and the tick gating.
    always_comb begin
        take_ctrl = ctrl_we && ctrl_accept(wdata);
        op        = tmr_op_e'(wdata[1:0]);
        src_tick  = sel_q[2] && tick_en[sel_q[1:0]];
        adv       = run_q && src_tick && !take_ctrl;
        hit       = adv && (cnt_q <= CNT_W'(1));
    end

    // Register update: reload value, command handling, counting and reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
            sel_q <= '0;
        end else begin
            if (div_we) begin
                div_q <= wdata[CNT_W-1:0];
            end
            if (take_ctrl) begin
                sel_q <= wdata[4:2];
                case (op)
                    OP_LOAD: cnt_q <= div_q;
                    OP_STOP: run_q <= 1'b0;
                    OP_RUN:  run_q <= 1'b1;
                    default: ;
                endcase
            end else if (adv) begin
                cnt_q <= hit ? div_q : cnt_q - CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/dtt_irq_agg.sv
// Interrupt aggregation: raw status set by timer hits, cleared by a
// write-one-to-clear acknowledge, gated by a mask into one level output.
// Assumes a hit wins over an acknowledge of the same bit in one cycle.
module dtt_irq_agg #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mask_we,
    input  logic         ack_we,
    input  logic [N-1:0] wbits,
    input  logic [N-1:0] hits,
    output logic [N-1:0] raw_q,
    output logic [N-1:0] mask_q,
    output logic [N-1:0] masked,
    output logic         irq
);

    logic [N-1:0] clr;

    // Select which raw bits the acknowledge clears this cycle.
    always_comb begin
        clr = ack_we ? wbits : '0;
    end

    // Status and mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q  <= '0;
            mask_q <= '0;
        end else begin
            raw_q <= (raw_q & ~clr) | hits;
            if (mask_we) begin
                mask_q <= wbits;
            end
        end
    end

    // Masked status and the level interrupt.
    always_comb begin
        masked = raw_q & mask_q;
        irq    = |masked;
    end

endmodule

// File: rtl/dual_tick_timer.sv
// Top of the dual tick timer: address decode, two timer channels, the
// interrupt aggregator and the read mux. Word accesses only; read data is
// combinational on the address.
module dual_tick_timer
    import dtt_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int CNT_W    = 32,
    parameter int NUM_TICK = 4,
    parameter int NUM_TMR  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_TICK-1:0] tick_en,
    output logic                irq
);

    logic [CNT_W-1:0]   div_vec [NUM_TMR];
    logic [CNT_W-1:0]   cnt_vec [NUM_TMR];
    logic [NUM_TMR-1:0] run_vec;
    logic [NUM_TMR-1:0] hit_vec;
    logic [NUM_TMR-1:0] raw_q;
    logic [NUM_TMR-1:0] mask_q;
    logic [NUM_TMR-1:0] masked;
    logic               mask_we;
    logic               ack_we;

    // Global register write decode.
    always_comb begin
        mask_we = bus_wr && (bus_addr == ADDR_W'(MASK_OFS));
        ack_we  = bus_wr && (bus_addr == ADDR_W'(ACK_OFS));
    end

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
        localparam int BASE = i * TMR_STRIDE;
        logic div_we;
        logic ctrl_we;

        // Per-channel write decode.
        always_comb begin
            div_we  = bus_wr && (bus_addr == ADDR_W'(BASE + TMR_DIV_OFS));
            ctrl_we = bus_wr && (bus_addr == ADDR_W'(BASE + TMR_CTRL_OFS));
        end

        dtt_timer_chan #(
            .CNT_W    (CNT_W),
            .NUM_TICK (NUM_TICK)
        ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .div_we  (div_we),
            .ctrl_we (ctrl_we),
            .wdata   (bus_wdata),
            .tick_en (tick_en),
            .div_q   (div_vec[i]),
            .cnt_q   (cnt_vec[i]),
            .run_q   (run_vec[i]),
            .hit     (hit_vec[i])
        );
    end

    dtt_irq_agg #(
        .N (NUM_TMR)
    ) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .mask_we (mask_we),
        .ack_we  (ack_we),
        .wbits   (bus_wdata[NUM_TMR-1:0]),
        .hits    (hit_vec),
        .raw_q   (raw_q),
        .mask_q  (mask_q),
        .masked  (masked),
        .irq     (irq)
    );

    // Read mux; unmapped and write-only offsets return zero.
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_TMR; i++) begin
            if (bus_addr == ADDR_W'(i * TMR_STRIDE + TMR_DIV_OFS)) begin
                bus_rdata = 32'(div_vec[i]);
            end
            if (bus_addr == ADDR_W'(i * TMR_STRIDE + TMR_CNT_OFS)) begin
                bus_rdata = 32'(cnt_vec[i]);
            end
        end
        if (bus_addr == ADDR_W'(MASK_OFS))   bus_rdata = 32'(mask_q);
        if (bus_addr == ADDR_W'(RAW_OFS))    bus_rdata = 32'(raw_q);
        if (bus_addr == ADDR_W'(MASKED_OFS)) bus_rdata = 32'(masked);
    end

endmodule

// File: rtl/dtt_checker.sv
// Property checker for the dual tick timer, attached by bind. Observes the
// bus, the hit pulses, the status registers and timer 0 state.
module dtt_checker
    import dtt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 32,
    parameter int N      = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              wbit0,
    input logic [N-1:0]      hits,
    input logic [N-1:0]      raw_q,
    input logic [N-1:0]      mask_q,
    input logic              irq,
    input logic              run0,
    input logic [CNT_W-1:0]  cnt0
);

    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq); // R7

    AST_HIT_SETS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        (|hits) |=> ((raw_q & $past(hits)) == $past(hits))); // R5

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(ACK_OFS) && wbit0 && !hits[0])
        |=> !raw_q[0]); // R6

    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!run0 && !(bus_wr && bus_addr == ADDR_W'(TMR_CTRL_OFS)))
        |=> $stable(cnt0)); // R4

    AST_RAW_ONLY_BY_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (!raw_q[0] && !hits[0]) |=> !raw_q[0]); // R9

endmodule

bind dual_tick_timer dtt_checker #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .N      (NUM_TMR)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .wbit0    (bus_wdata[0]),
    .hits     (hit_vec),
    .raw_q    (raw_q),
    .mask_q   (mask_q),
    .irq      (irq),
    .run0     (run_vec[0]),
    .cnt0     (cnt_vec[0])
);

// File: tb/tb_dual_tick_timer.sv
`timescale 1ns/1ps
module tb_dual_tick_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic [3:0]  tick_en = 4'h0;
    logic        irq;

    int checks = 0;
    int failures = 0;

    // Bench model state.
    logic [31:0] m_div [2];
    logic [31:0] m_cnt [2];
    logic        m_run [2];
    logic [2:0]  m_sel [2];
    logic [1:0]  m_raw;
    logic [1:0]  m_mask;

    dual_tick_timer dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tick_en   (tick_en),
        .irq       (irq)
    );

    always #5 clk = ~clk;

    function automatic logic ok_ctrl(input logic [31:0] w);
        return (w[1:0] != 2'd3) && !(w[4:2] == 3'd2 || w[4:2] == 3'd3) && (w[31:5] == 27'd0);
    endfunction

    function automatic logic [31:0] model_read(input logic [7:0] a);
        case (a)
            8'h00: return m_div[0];
            8'h04: return m_cnt[0];
            8'h10: return m_div[1];
            8'h14: return m_cnt[1];
            8'h48: return {30'd0, m_mask};
            8'h50: return {30'd0, m_raw};
            8'h54: return {30'd0, m_raw & m_mask};
            default: return 32'd0;
        endcase
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 2; i++) begin
            m_div[i] = 0; m_cnt[i] = 0; m_run[i] = 0; m_sel[i] = 0;
        end
        m_raw = 0; m_mask = 0;
    endtask

    // Apply one clock edge of stimulus to the model.
    task automatic model_step(input logic wr, input logic [7:0] a,
                              input logic [31:0] d, input logic [3:0] t);
        logic [1:0] hits;
        hits = 2'b00;
        for (int i = 0; i < 2; i++) begin
            logic acc;
            logic adv;
            logic [31:0] old_div;
            old_div = m_div[i];
            acc = wr && (a == 8'(16 * i + 8)) && ok_ctrl(d);
            adv = m_run[i] && m_sel[i][2] && t[m_sel[i][1:0]] && !acc;
            if (acc) begin
                m_sel[i] = d[4:2];
                if (d[1:0] == 2'd0) m_cnt[i] = old_div;
                if (d[1:0] == 2'd1) m_run[i] = 1'b0;
                if (d[1:0] == 2'd2) m_run[i] = 1'b1;
            end else if (adv) begin
                if (m_cnt[i] <= 1) begin
                    m_cnt[i] = old_div;
                    hits[i] = 1'b1;
                end else begin
                    m_cnt[i] = m_cnt[i] - 1;
                end
            end
            if (wr && a == 8'(16 * i)) m_div[i] = d;
        end
        m_raw = (m_raw & ~((wr && a == 8'h4C) ? d[1:0] : 2'b00)) | hits;
        if (wr && a == 8'h48) m_mask = d[1:0];
    endtask

    task automatic check(input logic ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One clock cycle of bus and tick stimulus.
    task automatic drive(input logic wr, input logic [7:0] a,
                         input logic [31:0] d, input logic [3:0] t);
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d; tick_en = t;
        @(posedge clk);
        model_step(wr, a, d, t);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        drive(1'b1, a, d, 4'h0);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_wr = 1'b0; tick_en = 4'h0; bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic expect_reg(input logic [7:0] a, input logic [31:0] exp, input string req);
        logic [31:0] v;
        rd(a, v);
        check(v == exp, req, $sformatf("reg@%0h", a), v, exp);
    endtask

    task automatic expect_irq(input logic exp, input string req);
        @(negedge clk);
        bus_wr = 1'b0; tick_en = 4'h0;
        #1 check(irq == exp, req, "irq", 32'(irq), 32'(exp));
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        expect_reg(8'h50, 0, "R1");
        expect_reg(8'h48, 0, "R1");
        expect_reg(8'h04, 0, "R1");
        expect_irq(1'b0, "R1");
        drive(1'b0, 8'h00, 0, 4'hF);
        expect_reg(8'h04, 0, "R1");

        // R2 / R10: load reload value
        wr(8'h00, 32'd5);
        wr(8'h08, 32'h10);
        expect_reg(8'h04, 5, "R2");
        expect_reg(8'h00, 5, "R10");

        // R3: run on source code 4 -> tick_en[0]
        wr(8'h08, 32'h12);
        repeat (3) drive(1'b0, 8'h00, 0, 4'b0001);
        expect_reg(8'h04, 2, "R3");
        drive(1'b0, 8'h00, 0, 4'b1110);
        expect_reg(8'h04, 2, "R3");

        // R5: expiry and reload
        repeat (2) drive(1'b0, 8'h00, 0, 4'b0001);
        expect_reg(8'h04, 5, "R5");
        expect_reg(8'h50, 1, "R5");
        expect_irq(1'b0, "R7");
        expect_reg(8'h54, 0, "R7");

        // R7: mask
        wr(8'h48, 32'h1);
        expect_irq(1'b1, "R7");
        expect_reg(8'h54, 1, "R7");

        // R6: acknowledge
        wr(8'h4C, 32'h2);
        expect_reg(8'h50, 1, "R6");
        wr(8'h4C, 32'h1);
        expect_reg(8'h50, 0, "R6");
        expect_irq(1'b0, "R6");
        expect_reg(8'h4C, 0, "R9");

        // R4: stop holds count
        wr(8'h08, 32'h11);
        repeat (2) drive(1'b0, 8'h00, 0, 4'b0001);
        expect_reg(8'h04, 5, "R4");

        // R8: ignored control words (still stopped)
        wr(8'h08, 32'h13);
        drive(1'b0, 8'h00, 0, 4'b0001);
        expect_reg(8'h04, 5, "R8");
        wr(8'h08, 32'h0A);
        drive(1'b0, 8'h00, 0, 4'b0001);
        expect_reg(8'h04, 5, "R8");
        wr(8'h08, 32'h32);
        drive(1'b0, 8'h00, 0, 4'b0001);
        expect_reg(8'h04, 5, "R8");

        // R3: run with clock code 0 never advances
        wr(8'h08, 32'h02);
        repeat (2) drive(1'b0, 8'h00, 0, 4'hF);
        expect_reg(8'h04, 5, "R3");

        // Timer 1 on code 7 -> tick_en[3]; expiry same cycle as ack (R6)
        wr(8'h10, 32'd3);
        wr(8'h18, 32'h1C);
        wr(8'h18, 32'h1E);
        repeat (2) drive(1'b0, 8'h00, 0, 4'b1000);
        expect_reg(8'h14, 1, "R10");
        drive(1'b1, 8'h4C, 32'h3, 4'b1000);
        expect_reg(8'h50, 2, "R6");
        expect_reg(8'h14, 3, "R5");

        // R9: unmapped and write-only reads, writes to status
        expect_reg(8'h20, 0, "R9");
        expect_reg(8'h08, 0, "R9");
        wr(8'h50, 32'h3);
        wr(8'h54, 32'h3);
        wr(8'h24, 32'hFFFF_FFFF);
        expect_reg(8'h50, 2, "R9");
        expect_reg(8'h04, 5, "R9");
        wr(8'h4C, 32'h3);

        // Random phase against the bench model.
        for (int n = 0; n < 4000; n++) begin
            logic [7:0]  a;
            logic [31:0] d;
            logic        w;
            case ($urandom_range(0, 10))
                0: a = 8'h00;  1: a = 8'h08;  2: a = 8'h10;  3: a = 8'h18;
                4: a = 8'h48;  5: a = 8'h4C;  6: a = 8'h50;  7: a = 8'h54;
                8: a = 8'h20;  default: a = 8'h04;
            endcase
            w = ($urandom_range(0, 3) == 0);
            if (a == 8'h00 || a == 8'h10) begin
                d = $urandom_range(0, 12);
            end else if (a == 8'h08 || a == 8'h18) begin
                d = {($urandom_range(0, 9) == 0) ? 27'($urandom) : 27'd0,
                     3'($urandom_range(0, 7)), 2'($urandom_range(0, 3))};
            end else begin
                d = $urandom;
            end
            drive(w, a, d, 4'($urandom));
            if (n % 7 == 6) begin
                expect_reg(8'h04, model_read(8'h04), "R3");
                expect_reg(8'h14, model_read(8'h14), "R3");
                expect_reg(8'h00, model_read(8'h00), "R2");
                expect_reg(8'h10, model_read(8'h10), "R2");
                expect_reg(8'h50, model_read(8'h50), "R5");
                expect_reg(8'h48, model_read(8'h48), "R7");
                expect_reg(8'h54, model_read(8'h54), "R7");
                expect_irq(|(m_raw & m_mask), "R7");
            end
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule